// File: doc/BRIEF.md
# Interrupt Line to Message Redirection Controller

This block watches a small set of wired interrupt inputs and turns each qualifying event into a message-signalled interrupt. A message-signalled interrupt is a single memory-write request that carries an address and a data word. Every input line owns a redirection entry made of two 32-bit words. The low word holds the vector, the input polarity, the trigger mode, a stored delivery-mode bit and a mask bit. The high word holds the destination and extended destination identifiers, which are folded into the message address.

Software has three byte offsets on a simple register bus. The first selects an internal index. The second is a data window onto the index last selected. The third is an end-of-interrupt (EOI) register that takes the vector of a serviced interrupt. Messages leave on a valid/ready interface. Only one message is outstanding at a time, and the lowest-numbered requesting line is served first.

Edge-triggered lines raise a pending flag on each active edge. Level-triggered lines send while active and then wait in service until a matching EOI. If a level line is still active when its EOI arrives, it sends again.

Top module: `irq_msg_redirect`

## Requirements
- R1: After reset, no message is valid and the select register reads zero. Every low word reads 0x0001_0000, so every line is masked, edge-triggered and active-high with vector 0. Every high word reads zero.
- R2: A write at byte offset 0x00 loads select[7:0]. A read at 0x00 returns the select value. Reads and writes at offset 0x10 act on the internal index held in select. A window read in the cycle after a window write returns the value just written.
- R3: Internal index 0x01 reads {8'h00, NUM_LINES-1, 8'h00, VERSION}, which is 0x0003_0021 with the default parameters. Writes to this index change nothing.
- R4: The low word of line n sits at index 0x10+2n and the high word at 0x11+2n. An index with no register behind it reads zero and ignores writes.
- R5: While low-word bit 16 (mask) is set, the line sends no message. An edge that arrives while the line is masked is discarded. Clearing the mask on an active level line sends a message.
- R6: With bit 15 clear, the line is edge-triggered. Each transition into the active state while unmasked yields exactly one message, and holding the input active yields no more. Bit 13 set makes the line active-low, so a falling input edge triggers it.
- R7: With bit 15 set, an active, unmasked line sends one message and then enters service. It sends nothing more until a matching EOI.
- R8: A write at offset 0x40 with data[7:0] equal to a level line's vector ends that line's service. If the input is still active, a new message follows. If the input is inactive, or the vector does not match, no message is sent.
- R9: The message data is {24'b0, low[7:0]}. The message address is 0xFEE0_0000 OR'd with high[31:24] shifted to bits 19:12 and high[23:16] shifted to bits 11:4.
- R10: When several lines request at once, the lowest-numbered line is sent first. A message stays valid, with address and data held stable, until ready is seen.
- R11: Low-word bit 8 is stored and reads back, but it has no effect on message content or delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Wired interrupt inputs, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted when high with valid |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions assume that irq_in is already synchronous to clk. They also assume that software changes an entry's polarity only while the input sits at its new inactive level; otherwise the reprogramming itself looks like an edge. The stimulus changes inputs only at falling clock edges. It sets an active-low line's input high before it writes the entry, and it issues EOI writes only for vectors that are in service or for a deliberately unmatched vector. The ready input is lowered only in the priority scenario, where the bench checks that the held message stays stable.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    // Byte offsets on the register bus
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] OFS_EOI = 8'h40;

    // Internal indices reached through the window
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam int         IDX_ENTRY0 = 16;

    // Low-word field positions
    localparam int B_ACTLOW = 13;
    localparam int B_LEVEL  = 15;
    localparam int B_MASK   = 16;

    localparam logic [31:0] LO_RESET = 32'h0001_0000;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic [7:0] vector;
    } line_cfg_t;

    function automatic line_cfg_t decode_lo(input logic [31:0] w);
        line_cfg_t c;
        c.mask    = w[B_MASK];
        c.level   = w[B_LEVEL];
        c.act_low = w[B_ACTLOW];
        c.vector  = w[7:0];
        return c;
    endfunction

    // dest = high[31:16] : destination id in [15:8], extended id in [7:0]
    function automatic logic [31:0] msg_address(input logic [31:0] base,
                                                input logic [15:0] dest);
        return base | {12'h000, dest[15:8], dest[7:0], 4'h0};
    endfunction

endpackage

// File: rtl/irqr_regfile.sv
module irqr_regfile
    import irqr_pkg::*;
#(
    parameter int         NUM_LINES = 4,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_wr,
    input  logic [7:0]                       bus_addr,
    input  logic [31:0]                      bus_wdata,
    output logic [31:0]                      bus_rdata,
    output line_cfg_t [NUM_LINES-1:0]        cfg,
    output logic [NUM_LINES-1:0][15:0]       dest,
    output logic                             eoi_stb,
    output logic [7:0]                       eoi_vec
);

    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

    logic [7:0]                    sel_q;
    logic                          win_wr;
    logic [NUM_LINES-1:0][31:0]    hit_data;
    logic [31:0]                   win_data;

    assign win_wr  = bus_wr && (bus_addr == OFS_WIN);
    assign eoi_stb = bus_wr && (bus_addr == OFS_EOI);
    assign eoi_vec = bus_wdata[7:0];

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (bus_wr && bus_addr == OFS_SEL)
            sel_q <= bus_wdata[7:0];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
        localparam logic [7:0] LO_IDX = 8'(IDX_ENTRY0 + 2 * g);
        localparam logic [7:0] HI_IDX = 8'(IDX_ENTRY0 + 2 * g + 1);
        logic [31:0] lo_q;
        logic [31:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= LO_RESET;
                hi_q <= '0;
            end else begin
                if (win_wr && sel_q == LO_IDX) lo_q <= bus_wdata;
                if (win_wr && sel_q == HI_IDX) hi_q <= bus_wdata;
            end
        end

        assign cfg[g]      = decode_lo(lo_q);
        assign dest[g]     = hi_q[31:16];
        assign hit_data[g] = (sel_q == LO_IDX) ? lo_q :
                             (sel_q == HI_IDX) ? hi_q : 32'h0;
    end

    always_comb begin
        win_data = (sel_q == IDX_VER) ? VER_WORD : 32'h0;
        for (int i = 0; i < NUM_LINES; i++)
            win_data = win_data | hit_data[i];
    end

    always_comb begin
        case (bus_addr)
            OFS_SEL: bus_rdata = {24'h0, sel_q};
            OFS_WIN: bus_rdata = win_data;
            default: bus_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/irqr_line.sv
module irqr_line
    import irqr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      irq_raw,
    input  line_cfg_t cfg,
    input  logic      accept,
    input  logic      eoi_stb,
    input  logic [7:0] eoi_vec,
    output logic      req
);

    logic active, prev_q, pend_q, insvc_q, rise;

    assign active = irq_raw ^ cfg.act_low;
    assign rise   = active & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pend_q  <= 1'b0;
            insvc_q <= 1'b0;
        end else begin
            prev_q <= active;
            // edge mode: a new edge outranks the accept of the older one
            if (cfg.level)                 pend_q <= 1'b0;
            else if (rise && !cfg.mask)    pend_q <= 1'b1;
            else if (accept)               pend_q <= 1'b0;
            // level mode: in service from accept until matching EOI
            if (!cfg.level)                                    insvc_q <= 1'b0;
            else if (accept)                                   insvc_q <= 1'b1;
            else if (eoi_stb && eoi_vec == cfg.vector)         insvc_q <= 1'b0;
        end
    end

    assign req = cfg.mask  ? 1'b0 :
                 cfg.level ? (active & ~insvc_q) : pend_q;

    // R7: a line enters service only through an accepted message
    p_insvc_from_accept_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(insvc_q) |-> $past(accept));

endmodule

// File: rtl/irqr_sender.sv
module irqr_sender
    import irqr_pkg::*;
#(
    parameter int          NUM_LINES = 4,
    parameter logic [31:0] MSG_BASE  = 32'hFEE0_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_LINES-1:0]          req,
    input  logic [NUM_LINES-1:0]          line_mask,
    input  logic [NUM_LINES-1:0][7:0]     vecs,
    input  logic [NUM_LINES-1:0][15:0]    dest,
    input  logic                          msg_ready,
    output logic                          msg_valid,
    output logic [31:0]                   msg_addr,
    output logic [31:0]                   msg_data,
    output logic [NUM_LINES-1:0]          accept
);

    localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [IW-1:0] pick, cur_q;
    logic          any, load, fire;

    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick = IW'(i);
                any  = 1'b1;
            end
        end
    end

    assign load = !msg_valid && any;
    assign fire = msg_valid && msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            cur_q     <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= msg_address(MSG_BASE, dest[pick]);
            msg_data  <= {24'h0, vecs[pick]};
            cur_q     <= pick;
        end else if (fire) begin
            msg_valid <= 1'b0;
        end
    end

    assign accept = fire ? (NUM_LINES'(1) << cur_q) : '0;

    // R10: a stalled message keeps its content
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R10: a new message only starts from a line request
    p_start_from_req_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(|req));

    // R5: never stage a message for a masked line
    p_no_masked_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |-> !line_mask[pick]);

endmodule

// File: rtl/irq_msg_redirect.sv
module irq_msg_redirect
    import irqr_pkg::*;
#(
    parameter int          NUM_LINES = 4,
    parameter logic [7:0]  VERSION   = 8'h21,
    parameter logic [31:0] MSG_BASE  = 32'hFEE0_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);

    line_cfg_t [NUM_LINES-1:0]       cfg;
    logic [NUM_LINES-1:0][15:0]      dest;
    logic [NUM_LINES-1:0][7:0]       vecs;
    logic [NUM_LINES-1:0]            line_mask, req, accept;
    logic                            eoi_stb;
    logic [7:0]                      eoi_vec;

    irqr_regfile #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg), .dest(dest),
        .eoi_stb(eoi_stb), .eoi_vec(eoi_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign vecs[g]      = cfg[g].vector;
        assign line_mask[g] = cfg[g].mask;
        irqr_line u_line (
            .clk(clk), .rst(rst), .irq_raw(irq_in[g]), .cfg(cfg[g]),
            .accept(accept[g]), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec), .req(req[g])
        );
    end

    irqr_sender #(.NUM_LINES(NUM_LINES), .MSG_BASE(MSG_BASE)) u_send (
        .clk(clk), .rst(rst), .req(req), .line_mask(line_mask), .vecs(vecs),
        .dest(dest), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .accept(accept)
    );

endmodule

// File: tb/irq_msg_redirect_test.sv
module irq_msg_redirect_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_msg_redirect uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic wait_msg(output bit got, output logic [31:0] a, output logic [31:0] d);
        got = 0; a = '0; d = '0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (msg_valid) begin
                got = 1; a = msg_addr; d = msg_data;
                break;
            end
        end
    endtask

    task automatic expect_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
        bit got; logic [31:0] a, d;
        wait_msg(got, a, d);
        check(got, {tag, " message present"}, 32'(got), 32'd1);
        check(got && d == ed, {tag, " message data"}, d, ed);
        check(got && a == ea, {tag, " message address"}, a, ea);
    endtask

    task automatic expect_none(input string tag, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (msg_valid) seen++;
        end
        check(seen == 0, {tag, " no message"}, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(msg_valid == 1'b0, "R1 valid after reset", 32'(msg_valid), 32'd0);
        bus_read(8'h00, d);
        check(d == 32'h0, "R1 select after reset", d, 32'h0);
        win_read(8'h10, d);
        check(d == 32'h0001_0000, "R1 low word reset", d, 32'h0001_0000);
        win_read(8'h17, d);
        check(d == 32'h0, "R1 high word reset", d, 32'h0);
    endtask

    task automatic t_version;
        logic [31:0] d;
        win_read(8'h01, d);
        check(d == 32'h0003_0021, "R3 version word", d, 32'h0003_0021);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, d);
        check(d == 32'h0003_0021, "R3 version read-only", d, 32'h0003_0021);
    endtask

    task automatic t_window;
        logic [31:0] d;
        win_write(8'h12, 32'h0001_0155);
        bus_read(8'h10, d);
        check(d == 32'h0001_0155, "R2 R11 readback after write", d, 32'h0001_0155);
        win_write(8'h15, 32'h1357_9BDF);
        bus_read(8'h10, d);
        check(d == 32'h1357_9BDF, "R4 high word line 2", d, 32'h1357_9BDF);
        win_write(8'h18, 32'hDEAD_BEEF);
        bus_read(8'h10, d);
        check(d == 32'h0, "R4 unimplemented index", d, 32'h0);
        bus_read(8'h00, d);
        check(d == 32'h18, "R2 select readback", d, 32'h18);
        win_read(8'h15, d);
        check(d == 32'h1357_9BDF, "R4 stray write left entry", d, 32'h1357_9BDF);
        win_write(8'h15, 32'h0);
        win_write(8'h12, 32'h0001_0041);
    endtask

    task automatic t_edge;
        win_write(8'h11, 32'h1234_0000);
        win_write(8'h10, 32'h0000_0040);
        @(negedge clk) irq_in[0] = 1'b1;
        expect_msg("R6 R9 edge line0", 32'hFEE1_2340, 32'h40);
        expect_none("R6 held input", 10);
        @(negedge clk) irq_in[0] = 1'b0;
        expect_none("R6 falling edge", 6);
    endtask

    task automatic t_polarity;
        @(negedge clk) irq_in[3] = 1'b1;
        win_write(8'h16, 32'h0000_2043);
        expect_none("R6 active-low idle", 6);
        @(negedge clk) irq_in[3] = 1'b0;
        expect_msg("R6 active-low falling edge", 32'hFEE0_0000, 32'h43);
        @(negedge clk) irq_in[3] = 1'b1;
        expect_none("R6 active-low release", 6);
    endtask

    task automatic t_mask_level;
        @(negedge clk) irq_in[1] = 1'b1;
        @(negedge clk) irq_in[1] = 1'b0;
        expect_none("R5 masked edge", 6);
        win_write(8'h12, 32'h0000_0041);
        expect_none("R5 discarded edge", 6);
        win_write(8'h12, 32'h0001_8041);
        @(negedge clk) irq_in[1] = 1'b1;
        expect_none("R5 masked level", 6);
        win_write(8'h12, 32'h0000_8141);
        expect_msg("R5 R7 R11 unmask level", 32'hFEE0_0000, 32'h41);
        expect_none("R7 in service", 10);
        bus_write(8'h40, 32'h55);
        expect_none("R8 unmatched EOI", 6);
        bus_write(8'h40, 32'h41);
        expect_msg("R8 EOI while active", 32'hFEE0_0000, 32'h41);
        @(negedge clk) irq_in[1] = 1'b0;
        bus_write(8'h40, 32'h41);
        expect_none("R8 EOI while inactive", 8);
    endtask

    task automatic t_priority;
        bit got; logic [31:0] a, d;
        int bad = 0;
        win_write(8'h12, 32'h0000_0041);
        win_write(8'h14, 32'h0000_0042);
        win_write(8'h15, 32'hAB00_0000);
        @(negedge clk) msg_ready = 1'b0;
        irq_in[2:1] = 2'b11;
        @(negedge clk) irq_in[2:1] = 2'b00;
        wait_msg(got, a, d);
        check(got && d == 32'h41, "R10 lowest line first", d, 32'h41);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!msg_valid || msg_data != 32'h41 || msg_addr != a) bad++;
        end
        check(bad == 0, "R10 held while not ready", 32'(bad), 32'd0);
        msg_ready = 1'b1;
        @(negedge clk);
        expect_msg("R10 R9 second line", 32'hFEEA_B000, 32'h42);
        expect_none("R10 queue drained", 6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_version();
        t_window();
        t_edge();
        t_polarity();
        t_mask_level();
        t_priority();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule